// File: doc/BRIEF.md
# Adaptive-Gain Frequency Acquisition Controller

This block steers the digital tuning word of an oscillator toward a target frequency. Every clock is one reference cycle. On each one, a phase/frequency detector outside the block reports two things: whether the oscillator runs fast or slow, and how large the frequency error is. The controller turns these into the next tuning word. It works through three modes in a fixed order: a coarse calibration search, a frequency acquisition phase, and tracking once locked.

During calibration the controller runs a bit-by-bit search on the upper bits of the tuning word. During acquisition a gain generator scales the step with the error magnitude and averages it with the step gain of the previous cycle. The fast/slow bit sets the direction of the step. Lock is therefore reached within a small, fixed number of cycles rather than after a full search.

Once the error stays under a programmable threshold, or the cycle budget runs out, the controller enters tracking. In tracking it only nudges the word by one LSB per cycle and raises the lock flag.

Top module: `freq_acq_ctrl`

## Requirements
- R1: While reset is high, and after it is released, the mode is calibration (code 0), the lock flag is 0 and the tuning word is the midpoint 2^(TW_W-1) (512 by default). Reset is synchronous.
- R2: Calibration lasts COARSE_W cycles (4 by default) and tests the COARSE_W most significant word bits one at a time, starting from the MSB. The bit under test is cleared when the detector reports fast (det_fast_i=1) and kept at 1 otherwise. The next lower coarse bit is then set as the new trial bit. The lower bits stay 0. After the last coarse bit the mode becomes acquisition (code 1).
- R3: In acquisition, the new gain is det_err_i shifted left by GAIN_SHIFT (1 by default). The applied step is (previous gain + new gain) / 2, rounded down. The previous gain is 0 on the first acquisition cycle. The word decreases by the step when det_fast_i=1 and increases by it otherwise.
- R4: In acquisition the tuning word saturates at 0 and at 2^TW_W-1 and never wraps.
- R5: Acquisition ends when det_err_i < lock_thr_i on two consecutive acquisition cycles. The mode is tracking (code 2) after the second of them. A single below-threshold cycle followed by a larger error does not end it.
- R6: Acquisition ends after at most BUDGET cycles (18 by default), whatever the error.
- R7: In tracking, the word moves by exactly one LSB per cycle: down when det_fast_i=1, up otherwise. It holds when det_err_i is 0 and saturates at both limits.
- R8: The lock flag is 1 exactly while the mode is tracking.
- R9: Tracking is left only by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, one decision per cycle |
| rst | input | 1 | Synchronous active-high reset |
| det_fast_i | input | 1 | 1 = oscillator above target, 0 = below |
| det_err_i | input | ERR_W | Frequency-error magnitude from the detector |
| lock_thr_i | input | ERR_W | Error level under which the loop counts as settled |
| tune_word_o | output | TW_W | Oscillator tuning word |
| mode_o | output | 2 | 0 calibration, 1 acquisition, 2 tracking |
| lock_o | output | 1 | Lock flag |

## Verification
Mode, word and lock flag are all held in registers. Each detector sample therefore shows up on the outputs at the first rising edge after it is applied, and the mode change that ends acquisition appears on that same edge. The bench drives inputs on the falling edge and advances its reference model on the next rising edge. It compares on the following falling edge, one cycle after each stimulus, with no extra latency. The directed checks also count cycles: calibration must hand over after exactly four samples, and acquisition with a persistently large error must hand over after exactly eighteen.

// File: rtl/freq_acq_pkg.sv
package freq_acq_pkg;

    typedef enum logic [1:0] {
        FA_CAL = 2'd0,
        FA_ACQ = 2'd1,
        FA_TRK = 2'd2
    } fa_mode_e;

    typedef struct packed {
        fa_mode_e mode;
        logic     lock;
    } fa_state_t;

    localparam fa_state_t FA_STATE_RST = '{mode: FA_CAL, lock: 1'b0};

endpackage

// File: rtl/fac_cal_search.sv
module fac_cal_search #(
    parameter int TW_W     = 10,
    parameter int COARSE_W = 4,
    parameter int CIDX_W   = 2
) (
    input  logic [TW_W-1:0]   tw_i,
    input  logic [CIDX_W-1:0] idx_i,
    input  logic              fast_i,
    output logic [TW_W-1:0]   tw_o,
    output logic              last_o
);
    localparam int LSB = TW_W - COARSE_W;

    always_comb begin
        tw_o = tw_i;
        for (int k = 0; k < COARSE_W; k++) begin
            if (CIDX_W'(k) == idx_i) begin
                tw_o[LSB+k] = ~fast_i;
            end
            if ((k + 1 < COARSE_W) && (CIDX_W'(k + 1) == idx_i)) begin
                tw_o[LSB+k] = 1'b1;
            end
        end
    end

    assign last_o = (idx_i == '0);

endmodule

// File: rtl/fac_gain_gen.sv
module fac_gain_gen #(
    parameter int ERR_W      = 8,
    parameter int GAIN_SHIFT = 1,
    parameter int G_W        = ERR_W + GAIN_SHIFT
) (
    input  logic [ERR_W-1:0] err_i,
    input  logic [G_W-1:0]   prev_i,
    output logic [G_W-1:0]   gain_o,
    output logic [G_W-1:0]   step_o
);
    logic [G_W:0] sum;

    assign gain_o = G_W'(err_i) << GAIN_SHIFT;
    assign sum    = {1'b0, prev_i} + {1'b0, gain_o};
    assign step_o = sum[G_W:1];

endmodule

// File: rtl/fac_lock_det.sv
module fac_lock_det #(
    parameter int ERR_W  = 8,
    parameter int BUDGET = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acq_i,
    input  logic [ERR_W-1:0] err_i,
    input  logic [ERR_W-1:0] thr_i,
    output logic             done_o
);
    localparam int CNT_W = $clog2(BUDGET + 1);

    logic             below;
    logic             prev_below_q;
    logic [CNT_W-1:0] cnt_q;

    assign below  = (err_i < thr_i);
    assign done_o = acq_i && ((below && prev_below_q) || (cnt_q == CNT_W'(BUDGET - 1)));

    always_ff @(posedge clk) begin
        if (rst || !acq_i) begin
            prev_below_q <= 1'b0;
            cnt_q        <= '0;
        end else begin
            prev_below_q <= below;
            cnt_q        <= cnt_q + 1'b1;
        end
    end

    // R6: the acquisition counter never passes the budget
    a_r6_budget_bound: assert property (@(posedge clk) disable iff (rst)
        acq_i |-> (cnt_q < CNT_W'(BUDGET)));

endmodule

// File: rtl/freq_acq_ctrl.sv
module freq_acq_ctrl
    import freq_acq_pkg::*;
#(
    parameter int TW_W       = 10,
    parameter int COARSE_W   = 4,
    parameter int ERR_W      = 8,
    parameter int GAIN_SHIFT = 1,
    parameter int BUDGET     = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             det_fast_i,
    input  logic [ERR_W-1:0] det_err_i,
    input  logic [ERR_W-1:0] lock_thr_i,
    output logic [TW_W-1:0]  tune_word_o,
    output logic [1:0]       mode_o,
    output logic             lock_o
);
    localparam int G_W    = ERR_W + GAIN_SHIFT;
    localparam int X_W    = ((TW_W > G_W) ? TW_W : G_W) + 1;
    localparam int CIDX_W = (COARSE_W > 1) ? $clog2(COARSE_W) : 1;
    localparam logic [TW_W-1:0] TW_MAX = '1;
    localparam logic [TW_W-1:0] TW_MID = TW_W'(1) << (TW_W - 1);

    fa_state_t         st_q, st_d;
    logic [TW_W-1:0]   tw_q, tw_d;
    logic [G_W-1:0]    pg_q, pg_d;
    logic [CIDX_W-1:0] ci_q, ci_d;

    logic [TW_W-1:0]   cal_tw;
    logic              cal_last;
    logic [G_W-1:0]    gain, step;
    logic              acq_done;
    logic [X_W-1:0]    tw_x, step_x, up_x;
    logic [TW_W-1:0]   acq_tw, trk_tw;

    fac_cal_search #(.TW_W(TW_W), .COARSE_W(COARSE_W), .CIDX_W(CIDX_W)) cal_u (
        .tw_i   (tw_q),
        .idx_i  (ci_q),
        .fast_i (det_fast_i),
        .tw_o   (cal_tw),
        .last_o (cal_last)
    );

    fac_gain_gen #(.ERR_W(ERR_W), .GAIN_SHIFT(GAIN_SHIFT), .G_W(G_W)) gain_u (
        .err_i  (det_err_i),
        .prev_i (pg_q),
        .gain_o (gain),
        .step_o (step)
    );

    fac_lock_det #(.ERR_W(ERR_W), .BUDGET(BUDGET)) lock_u (
        .clk    (clk),
        .rst    (rst),
        .acq_i  (st_q.mode == FA_ACQ),
        .err_i  (det_err_i),
        .thr_i  (lock_thr_i),
        .done_o (acq_done)
    );

    // saturating acquisition step
    always_comb begin
        tw_x   = X_W'(tw_q);
        step_x = X_W'(step);
        up_x   = tw_x + step_x;
        if (det_fast_i) begin
            acq_tw = (step_x > tw_x) ? '0 : TW_W'(tw_x - step_x);
        end else begin
            acq_tw = (up_x > X_W'(TW_MAX)) ? TW_MAX : TW_W'(up_x);
        end
    end

    // single-LSB tracking step
    always_comb begin
        trk_tw = tw_q;
        if (det_err_i != '0) begin
            if (det_fast_i) begin
                if (tw_q != '0) trk_tw = tw_q - 1'b1;
            end else begin
                if (tw_q != TW_MAX) trk_tw = tw_q + 1'b1;
            end
        end
    end

    always_comb begin
        st_d = st_q;
        tw_d = tw_q;
        pg_d = pg_q;
        ci_d = ci_q;
        unique case (st_q.mode)
            FA_CAL: begin
                tw_d = cal_tw;
                pg_d = '0;
                if (cal_last) st_d.mode = FA_ACQ;
                else          ci_d = ci_q - 1'b1;
            end
            FA_ACQ: begin
                tw_d = acq_tw;
                pg_d = gain;
                if (acq_done) begin
                    st_d.mode = FA_TRK;
                    st_d.lock = 1'b1;
                end
            end
            FA_TRK: tw_d = trk_tw;
            default: st_d = FA_STATE_RST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= FA_STATE_RST;
            tw_q <= TW_MID;
            pg_q <= '0;
            ci_q <= CIDX_W'(COARSE_W - 1);
        end else begin
            st_q <= st_d;
            tw_q <= tw_d;
            pg_q <= pg_d;
            ci_q <= ci_d;
        end
    end

    assign tune_word_o = tw_q;
    assign mode_o      = st_q.mode;
    assign lock_o      = st_q.lock;

    // R1: reset leaves the calibration start point
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (st_q.mode == FA_CAL && tw_q == TW_MID && !st_q.lock));

    // R2: modes only advance, acquisition never returns to calibration
    a_r2_mode_order: assert property (@(posedge clk) disable iff (rst)
        (st_q.mode == FA_ACQ) |=> (st_q.mode != FA_CAL));

    // R3: a fast report in acquisition never raises the word
    a_r3_fast_lowers: assert property (@(posedge clk) disable iff (rst)
        (st_q.mode == FA_ACQ && det_fast_i) |=> (tw_q <= $past(tw_q)));

    // R7: tracking moves by at most one LSB
    a_r7_unit_step: assert property (@(posedge clk) disable iff (rst)
        (st_q.mode == FA_TRK) |=> (tw_q == $past(tw_q) ||
                                   tw_q == $past(tw_q) + 1'b1 ||
                                   tw_q == $past(tw_q) - 1'b1));

    // R8: lock flag coincides with tracking
    a_r8_lock_match: assert property (@(posedge clk) disable iff (rst)
        st_q.lock == (st_q.mode == FA_TRK));

    // R9: tracking is sticky
    a_r9_track_sticky: assert property (@(posedge clk) disable iff (rst)
        (st_q.mode == FA_TRK) |=> (st_q.mode == FA_TRK));

endmodule

// File: tb/freq_acq_ctrl_tb_top.sv
`timescale 1ns/1ps
module freq_acq_ctrl_tb_top;
    localparam int TW_W       = 10;
    localparam int COARSE_W   = 4;
    localparam int ERR_W      = 8;
    localparam int GAIN_SHIFT = 1;
    localparam int BUDGET     = 18;
    localparam int WMAX       = (1 << TW_W) - 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             fast = 1'b0;
    logic [ERR_W-1:0] err = '0;
    logic [ERR_W-1:0] thr = '0;
    logic [TW_W-1:0]  tw;
    logic [1:0]       mode;
    logic             lock;

    always #10 clk = ~clk;

    freq_acq_ctrl #(
        .TW_W(TW_W), .COARSE_W(COARSE_W), .ERR_W(ERR_W),
        .GAIN_SHIFT(GAIN_SHIFT), .BUDGET(BUDGET)
    ) dut_i (
        .clk(clk), .rst(rst), .det_fast_i(fast), .det_err_i(err),
        .lock_thr_i(thr), .tune_word_o(tw), .mode_o(mode), .lock_o(lock)
    );

    int total = 0;
    int bad   = 0;
    int m_word, m_mode, m_lock, m_prev, m_below, m_cnt, m_idx;

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic void model_reset();
        m_word = 1 << (TW_W - 1);
        m_mode = 0; m_lock = 0; m_prev = 0; m_below = 0; m_cnt = 0;
        m_idx  = COARSE_W - 1;
    endfunction

    function automatic void model_step(bit f, int e, int t);
        int pos, g, s;
        bit b;
        case (m_mode)
            0: begin
                pos = TW_W - COARSE_W + m_idx;
                if (f) m_word = m_word & ~(1 << pos);
                else   m_word = m_word | (1 << pos);
                if (m_idx > 0) begin
                    m_word = m_word | (1 << (pos - 1));
                    m_idx--;
                end else begin
                    m_mode = 1; m_prev = 0; m_below = 0; m_cnt = 0;
                end
            end
            1: begin
                g = e << GAIN_SHIFT;
                s = (m_prev + g) / 2;
                if (f) m_word = (m_word - s < 0) ? 0 : m_word - s;
                else   m_word = (m_word + s > WMAX) ? WMAX : m_word + s;
                m_prev = g;
                b = (e < t);
                if ((b && m_below) || m_cnt == BUDGET - 1) begin
                    m_mode = 2; m_lock = 1;
                end
                m_below = b;
                m_cnt++;
            end
            default: begin
                if (e != 0) begin
                    if (f && m_word > 0) m_word--;
                    else if (!f && m_word < WMAX) m_word++;
                end
            end
        endcase
    endfunction

    task automatic do_reset(int t);
        rst = 1'b1; thr = ERR_W'(t); fast = 1'b0; err = '0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        chk("R1 mode", int'(mode), 0);
        chk("R1 word", int'(tw), 1 << (TW_W - 1));
        chk("R1 lock", int'(lock), 0);
    endtask

    task automatic step(bit f, int e);
        int pm;
        string wt, mt;
        pm = m_mode;
        fast = f; err = ERR_W'(e);
        @(posedge clk);
        model_step(f, e, int'(thr));
        @(negedge clk);
        wt = (pm == 0) ? "R2 word" : (pm == 1) ? "R3/R4 word" : "R7 word";
        mt = (pm == 0) ? "R2 mode" : (pm == 1) ? "R5/R6 mode" : "R9 mode";
        chk(wt, int'(tw), m_word);
        chk(mt, int'(mode), m_mode);
        chk("R8 lock", int'(lock), m_lock);
    endtask

    initial begin
        #(20 * 100000);
        total++; bad++;
        $display("FAIL watchdog R1 act=hung exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd7321));

        // all-fast calibration, then large error pinned at zero until budget
        do_reset(4);
        for (int i = 0; i < COARSE_W; i++) step(1'b1, 100);
        chk("R2 all-fast word", int'(tw), 0);
        chk("R2 enter acq", int'(mode), 1);
        for (int i = 0; i < BUDGET - 1; i++) step(1'b1, 200);
        chk("R6 still acq", int'(mode), 1);
        step(1'b1, 200);
        chk("R6 budget ends acq", int'(mode), 2);
        chk("R4 floor", int'(tw), 0);
        for (int i = 0; i < 3; i++) step(1'b1, 5);
        chk("R7 floor hold", int'(tw), 0);

        // all-slow calibration, ceiling, two-cycle lock, tracking
        do_reset(10);
        for (int i = 0; i < COARSE_W; i++) step(1'b0, 50);
        chk("R2 all-slow word", int'(tw), 960);
        step(1'b0, 255);
        chk("R4 ceiling", int'(tw), WMAX);
        step(1'b1, 3);
        chk("R5 one below", int'(mode), 1);
        step(1'b1, 3);
        chk("R5 two below", int'(mode), 2);
        chk("R5 word", int'(tw), 759);
        step(1'b0, 0);
        chk("R7 zero error hold", int'(tw), 759);
        step(1'b0, 9);
        chk("R7 up one", int'(tw), 760);
        step(1'b1, 9);
        chk("R7 down one", int'(tw), 759);
        for (int i = 0; i < 30; i++) step(1'($urandom_range(0, 1)), int'($urandom_range(0, 255)));
        chk("R9 still tracking", int'(mode), 2);

        // alternating calibration, averaged steps, interrupted settling
        do_reset(10);
        step(1'b1, 0); step(1'b0, 0); step(1'b1, 0); step(1'b0, 0);
        chk("R2 alternating word", int'(tw), 320);
        step(1'b0, 40);
        chk("R3 first step", int'(tw), 360);
        step(1'b1, 20);
        chk("R3 averaged step", int'(tw), 300);
        step(1'b0, 5);
        step(1'b0, 30);
        chk("R5 interrupted", int'(mode), 1);
        step(1'b0, 5);
        step(1'b0, 5);
        chk("R5 relock", int'(mode), 2);

        // random runs
        for (int r = 0; r < 8; r++) begin
            do_reset(int'($urandom_range(1, 40)));
            for (int i = 0; i < 60; i++) begin
                int hi;
                hi = 255 >> (i / 6);
                if (hi < 1) hi = 1;
                step(1'($urandom_range(0, 1)), int'($urandom_range(0, hi)));
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule